// File: doc/BRIEF.md
# Read-After-Write Decode Interlock for a Five-Stage Pipeline

This block holds the pipeline control of an in-order core whose work is split into fetch, decode, execute, memory and writeback. A pipeline register sits between each pair of neighbouring stages. The core has no operand bypass paths. A decoding instruction must therefore wait until every older instruction that writes one of its source registers has reached writeback.

The interlock compares each source register index of the instruction in decode with the destination index of the instructions in execute and in memory. A comparison counts only when the source is actually read and is not register 0, and the older instruction is valid, writes a register, and targets a non-zero index. Any such match raises the stall in the same cycle that the dependent instruction sits in decode. While the stall is high, the fetch PC and the decode register hold their contents, a bubble enters execute, and the later stages keep draining.

Writeback is never compared. The register file writes in the first half of a cycle and reads in the second half, so a producer in writeback already hands its value to decode. Anti and output dependences never stall, because results are written in program order from a single stage.

A thin wrapper of valid bits, PCs and register indices carries each instruction from fetch to writeback. The stall can therefore be observed at the ports as held PCs and delayed retirements.

Top module: `rawchk_pipe`

## Requirements
- R1: While reset is asserted, `stall` is 0, `retire_valid` is 0 and `fetch_pc` is 0.
- R2: A used, non-zero source of a valid decoding instruction that equals the destination of a valid, writing instruction in execute raises `stall`. A consumer directly behind its producer therefore waits two extra cycles in decode.
- R3: A used, non-zero source that matches a valid writer in the memory stage raises `stall`. A consumer two slots behind its producer waits one extra cycle.
- R4: A producer in writeback never causes a stall. A consumer three or more slots behind its producer goes on without waiting.
- R5: Write-after-read and write-after-write relations never stall. This covers a consumer whose destination equals an older instruction's source or destination.
- R6: Register index 0 is never a producer. A writer with destination 0 does not stall a reader of register 0.
- R7: A source field whose use flag (`f_use_rs1` or `f_use_rs2`) is 0 never causes a stall, whatever its index.
- R8: An older slot does not cause a stall if it is invalid (`f_valid` 0 at fetch) or has its write enable (`f_wen`) at 0, even when its destination matches.
- R9: When `stall` is high at a clock edge, `fetch_pc` and the decode register keep their values and execute receives a bubble. When `stall` is low, `fetch_pc` increments by 1 and the presented fetch slot is taken, so the slot taken at an edge carries the PC shown before that edge.
- R10: Every valid instruction retires exactly once and in program order. `retire_valid` rises two edges after the instruction enters execute and shows its PC, destination and write enable.
- R11: A match on the second source alone raises `stall` in the same way as a match on the first source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_valid | input | 1 | Fetched slot holds a real instruction |
| f_rs1 | input | IDX_W | First source register index |
| f_use_rs1 | input | 1 | First source is read |
| f_rs2 | input | IDX_W | Second source register index |
| f_use_rs2 | input | 1 | Second source is read |
| f_rd | input | IDX_W | Destination register index |
| f_wen | input | 1 | Instruction writes its destination |
| stall | output | 1 | Decode interlock: hold PC and decode, bubble into execute |
| fetch_pc | output | PC_W | PC of the slot taken at the next unstalled edge |
| retire_valid | output | 1 | Writeback stage holds a valid instruction |
| retire_pc | output | PC_W | PC of the instruction in writeback |
| retire_rd | output | IDX_W | Destination of the instruction in writeback |
| retire_wen | output | 1 | Write enable of the instruction in writeback |

## Verification
The hardest case to reach from the ports is a consumer that stays stalled while its producer moves from execute into memory. The stall must hold for exactly the cycles needed and no longer, and any bubble or invalid slot between producer and consumer must not add a cycle or take one away. The stimulus builds instruction streams with exact spacing, using idle fetch slots and invalid slots that carry matching destinations. It also chains dependences so that each consumer becomes the next producer. A reference that tracks only the last two slots predicts the edge at which each slot is taken and the edge at which each instruction retires. Any extra or missing stall cycle therefore shows up as a shifted acceptance or retirement.

// File: rtl/rawchk_pkg.sv
package rawchk_pkg;

  // Later stages that are compared against decode. Writeback is excluded on
  // purpose: the register file writes early and reads late in a cycle.
  typedef enum int unsigned {
    PS_EX  = 0,
    PS_MEM = 1
  } prod_stage_e;

  localparam int unsigned N_PROD_STAGES = 2;
  localparam int unsigned N_SOURCES     = 2;

  // An older instruction can supply a value only if it is real, writes, and
  // targets a register other than the hard-wired zero.
  function automatic logic producer_live(input logic vld, input logic wen,
                                         input logic rd_nonzero);
    return vld & wen & rd_nonzero;
  endfunction

  // A source needs checking only if the decode slot is real, the field is
  // read, and it does not name the zero register.
  function automatic logic source_live(input logic vld, input logic used,
                                       input logic rs_nonzero);
    return vld & used & rs_nonzero;
  endfunction

endpackage

// File: rtl/rawchk_src_match.sv
module rawchk_src_match #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned N_PROD = 2
) (
  input  logic                         src_live,
  input  logic [IDX_W-1:0]             src_idx,
  input  logic [N_PROD-1:0]            prod_live,
  input  logic [N_PROD-1:0][IDX_W-1:0] prod_idx,
  output logic [N_PROD-1:0]            hit
);

  // One equality comparator per later stage for this source field.
  for (genvar p = 0; p < N_PROD; p++) begin : g_cmp
    assign hit[p] = src_live & prod_live[p] & (src_idx == prod_idx[p]);
  end

endmodule

// File: rtl/rawchk_hazard_unit.sv
module rawchk_hazard_unit
  import rawchk_pkg::*;
#(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned N_SRC  = N_SOURCES,
  parameter int unsigned N_PROD = N_PROD_STAGES
) (
  input  logic                         dec_vld,
  input  logic [N_SRC-1:0][IDX_W-1:0]  dec_src,
  input  logic [N_SRC-1:0]             dec_use,
  input  logic [N_PROD-1:0]            prod_vld,
  input  logic [N_PROD-1:0]            prod_wen,
  input  logic [N_PROD-1:0][IDX_W-1:0] prod_rd,
  output logic                         raw_stall
);

  logic [N_PROD-1:0]            prod_live;
  logic [N_SRC-1:0]             src_live;
  logic [N_SRC-1:0][N_PROD-1:0] hit_mat;
  logic [N_SRC-1:0]             src_hit;

  for (genvar p = 0; p < N_PROD; p++) begin : g_prod
    assign prod_live[p] = producer_live(prod_vld[p], prod_wen[p], |prod_rd[p]);
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign src_live[s] = source_live(dec_vld, dec_use[s], |dec_src[s]);

    rawchk_src_match #(
      .IDX_W  (IDX_W),
      .N_PROD (N_PROD)
    ) u_match (
      .src_live  (src_live[s]),
      .src_idx   (dec_src[s]),
      .prod_live (prod_live),
      .prod_idx  (prod_rd),
      .hit       (hit_mat[s])
    );

    assign src_hit[s] = |hit_mat[s];
  end

  // Stall at once on any true dependence; anti and output relations are
  // never compared at all.
  assign raw_stall = |src_hit;

endmodule

// File: rtl/rawchk_pipe_regs.sv
module rawchk_pipe_regs #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned PC_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             f_valid,
  input  logic [IDX_W-1:0] f_rs1,
  input  logic             f_use_rs1,
  input  logic [IDX_W-1:0] f_rs2,
  input  logic             f_use_rs2,
  input  logic [IDX_W-1:0] f_rd,
  input  logic             f_wen,
  output logic [PC_W-1:0]  pc_q,
  output logic             id_vld,
  output logic [PC_W-1:0]  id_pc,
  output logic [IDX_W-1:0] id_rs1,
  output logic             id_use1,
  output logic [IDX_W-1:0] id_rs2,
  output logic             id_use2,
  output logic [IDX_W-1:0] id_rd,
  output logic             id_wen,
  output logic             ex_vld,
  output logic [PC_W-1:0]  ex_pc,
  output logic [IDX_W-1:0] ex_rd,
  output logic             ex_wen,
  output logic             mem_vld,
  output logic [PC_W-1:0]  mem_pc,
  output logic [IDX_W-1:0] mem_rd,
  output logic             mem_wen,
  output logic             wb_vld,
  output logic [PC_W-1:0]  wb_pc,
  output logic [IDX_W-1:0] wb_rd,
  output logic             wb_wen
);

  // Front end: PC and IF/ID freeze while the interlock holds.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      id_vld  <= 1'b0;
      id_pc   <= '0;
      id_rs1  <= '0;
      id_use1 <= 1'b0;
      id_rs2  <= '0;
      id_use2 <= 1'b0;
      id_rd   <= '0;
      id_wen  <= 1'b0;
    end else if (!hold) begin
      pc_q    <= pc_q + 1'b1;
      id_vld  <= f_valid;
      id_pc   <= pc_q;
      id_rs1  <= f_rs1;
      id_use1 <= f_use_rs1;
      id_rs2  <= f_rs2;
      id_use2 <= f_use_rs2;
      id_rd   <= f_rd;
      id_wen  <= f_wen;
    end
  end

  // ID/EX: a held decode slot turns into a bubble in execute.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_vld <= 1'b0;
      ex_pc  <= '0;
      ex_rd  <= '0;
      ex_wen <= 1'b0;
    end else begin
      ex_vld <= id_vld & ~hold;
      ex_pc  <= id_pc;
      ex_rd  <= id_rd;
      ex_wen <= id_wen;
    end
  end

  // Back end always advances.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_vld <= 1'b0;
      mem_pc  <= '0;
      mem_rd  <= '0;
      mem_wen <= 1'b0;
      wb_vld  <= 1'b0;
      wb_pc   <= '0;
      wb_rd   <= '0;
      wb_wen  <= 1'b0;
    end else begin
      mem_vld <= ex_vld;
      mem_pc  <= ex_pc;
      mem_rd  <= ex_rd;
      mem_wen <= ex_wen;
      wb_vld  <= mem_vld;
      wb_pc   <= mem_pc;
      wb_rd   <= mem_rd;
      wb_wen  <= mem_wen;
    end
  end

endmodule

// File: rtl/rawchk_pipe.sv
module rawchk_pipe
  import rawchk_pkg::*;
#(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned PC_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             f_valid,
  input  logic [IDX_W-1:0] f_rs1,
  input  logic             f_use_rs1,
  input  logic [IDX_W-1:0] f_rs2,
  input  logic             f_use_rs2,
  input  logic [IDX_W-1:0] f_rd,
  input  logic             f_wen,
  output logic             stall,
  output logic [PC_W-1:0]  fetch_pc,
  output logic             retire_valid,
  output logic [PC_W-1:0]  retire_pc,
  output logic [IDX_W-1:0] retire_rd,
  output logic             retire_wen
);

  logic             id_vld, id_use1, id_use2, id_wen;
  logic [PC_W-1:0]  id_pc;
  logic [IDX_W-1:0] id_rs1, id_rs2, id_rd;
  logic             ex_vld, ex_wen, mem_vld, mem_wen;
  logic [PC_W-1:0]  ex_pc, mem_pc;
  logic [IDX_W-1:0] ex_rd, mem_rd;

  logic [N_SOURCES-1:0][IDX_W-1:0]     dec_src;
  logic [N_SOURCES-1:0]                dec_use;
  logic [N_PROD_STAGES-1:0]            prod_vld, prod_wen;
  logic [N_PROD_STAGES-1:0][IDX_W-1:0] prod_rd;

  rawchk_pipe_regs #(
    .IDX_W (IDX_W),
    .PC_W  (PC_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (stall),
    .f_valid   (f_valid),
    .f_rs1     (f_rs1),
    .f_use_rs1 (f_use_rs1),
    .f_rs2     (f_rs2),
    .f_use_rs2 (f_use_rs2),
    .f_rd      (f_rd),
    .f_wen     (f_wen),
    .pc_q      (fetch_pc),
    .id_vld    (id_vld),
    .id_pc     (id_pc),
    .id_rs1    (id_rs1),
    .id_use1   (id_use1),
    .id_rs2    (id_rs2),
    .id_use2   (id_use2),
    .id_rd     (id_rd),
    .id_wen    (id_wen),
    .ex_vld    (ex_vld),
    .ex_pc     (ex_pc),
    .ex_rd     (ex_rd),
    .ex_wen    (ex_wen),
    .mem_vld   (mem_vld),
    .mem_pc    (mem_pc),
    .mem_rd    (mem_rd),
    .mem_wen   (mem_wen),
    .wb_vld    (retire_valid),
    .wb_pc     (retire_pc),
    .wb_rd     (retire_rd),
    .wb_wen    (retire_wen)
  );

  assign dec_src = {id_rs2, id_rs1};
  assign dec_use = {id_use2, id_use1};

  assign prod_vld[PS_EX]  = ex_vld;
  assign prod_wen[PS_EX]  = ex_wen;
  assign prod_rd[PS_EX]   = ex_rd;
  assign prod_vld[PS_MEM] = mem_vld;
  assign prod_wen[PS_MEM] = mem_wen;
  assign prod_rd[PS_MEM]  = mem_rd;

  rawchk_hazard_unit #(
    .IDX_W  (IDX_W),
    .N_SRC  (N_SOURCES),
    .N_PROD (N_PROD_STAGES)
  ) u_hazard (
    .dec_vld   (id_vld),
    .dec_src   (dec_src),
    .dec_use   (dec_use),
    .prod_vld  (prod_vld),
    .prod_wen  (prod_wen),
    .prod_rd   (prod_rd),
    .raw_stall (stall)
  );

endmodule

// File: rtl/rawchk_pipe_chk.sv
module rawchk_pipe_chk #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned PC_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic [PC_W-1:0]  fetch_pc,
  input logic             id_vld,
  input logic [PC_W-1:0]  id_pc,
  input logic [IDX_W-1:0] id_rs1,
  input logic             id_use1,
  input logic [IDX_W-1:0] id_rs2,
  input logic             id_use2,
  input logic             ex_vld,
  input logic [IDX_W-1:0] ex_rd,
  input logic             ex_wen,
  input logic             mem_vld,
  input logic [IDX_W-1:0] mem_rd,
  input logic             mem_wen,
  input logic             retire_valid
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!stall && !retire_valid && fetch_pc == '0));

  assert_ex_match_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (id_vld && id_use1 && id_rs1 != '0 && ex_vld && ex_wen && ex_rd == id_rs1)
    |-> stall);

  assert_mem_match_stalls_R3_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (id_vld && id_use2 && id_rs2 != '0 && mem_vld && mem_wen && mem_rd == id_rs2)
    |-> stall);

  assert_no_live_source_no_stall_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_vld && (!id_use1 || id_rs1 == '0) && (!id_use2 || id_rs2 == '0)) |-> !stall);

  assert_empty_decode_no_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !id_vld |-> !stall);

  assert_stall_holds_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> fetch_pc == $past(fetch_pc));

  assert_stall_holds_decode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (id_vld && id_pc == $past(id_pc)));

  assert_stall_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_vld);

  assert_retire_from_ex_R10: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> $past(ex_vld, 2));

endmodule

bind rawchk_pipe rawchk_pipe_chk #(
  .IDX_W (IDX_W),
  .PC_W  (PC_W)
) u_rawchk_pipe_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stall        (stall),
  .fetch_pc     (fetch_pc),
  .id_vld       (id_vld),
  .id_pc        (id_pc),
  .id_rs1       (id_rs1),
  .id_use1      (id_use1),
  .id_rs2       (id_rs2),
  .id_use2      (id_use2),
  .ex_vld       (ex_vld),
  .ex_rd        (ex_rd),
  .ex_wen       (ex_wen),
  .mem_vld      (mem_vld),
  .mem_rd       (mem_rd),
  .mem_wen      (mem_wen),
  .retire_valid (retire_valid)
);

// File: tb/test_rawchk_pipe.sv
`timescale 1ns/1ps
module test_rawchk_pipe;
  localparam int IDX_W = 5;
  localparam int PC_W  = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             f_valid = 1'b0, f_use_rs1 = 1'b0, f_use_rs2 = 1'b0, f_wen = 1'b0;
  logic [IDX_W-1:0] f_rs1 = '0, f_rs2 = '0, f_rd = '0;
  logic             stall, retire_valid, retire_wen;
  logic [PC_W-1:0]  fetch_pc, retire_pc;
  logic [IDX_W-1:0] retire_rd;

  always #2 clk = ~clk;

  rawchk_pipe #(.IDX_W(IDX_W), .PC_W(PC_W)) i_rawchk_pipe (
    .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_rs1(f_rs1),
    .f_use_rs1(f_use_rs1), .f_rs2(f_rs2), .f_use_rs2(f_use_rs2),
    .f_rd(f_rd), .f_wen(f_wen), .stall(stall), .fetch_pc(fetch_pc),
    .retire_valid(retire_valid), .retire_pc(retire_pc),
    .retire_rd(retire_rd), .retire_wen(retire_wen)
  );

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  always @(posedge clk) edges <= edges + 1;

  typedef struct {int pc; int rd; bit we; int edge_no;} exp_t;
  exp_t sbq[$];
  exp_t mon_e;

  // Reference state: the two most recent fetch slots.
  int pc_model = 0;
  int p1_x = 0, p2_x = 0;
  bit p1_live = 0, p2_live = 0;
  int p1_rd = 0, p2_rd = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: present one fetch slot until it is taken, predict the edges at
  // which it is taken and retires, and push the expected retirement.
  task automatic slot(input bit v, input int rs1, input bit u1, input int rs2,
                      input bit u2, input int rd, input bit we, input string req);
    int  pred_a, a, x;
    bit  acc;
    pred_a = (p1_x > edges) ? p1_x : edges + 1;
    f_valid = v; f_rs1 = rs1[IDX_W-1:0]; f_use_rs1 = u1;
    f_rs2 = rs2[IDX_W-1:0]; f_use_rs2 = u2; f_rd = rd[IDX_W-1:0]; f_wen = we;
    acc = 1'b0;
    while (!acc) begin
      check(int'(fetch_pc) == pc_model, "R9", "fetch_pc", int'(fetch_pc), pc_model);
      acc = !stall;
      @(posedge clk);
      @(negedge clk);
    end
    a = edges;
    check(a == pred_a, req, "slot accept edge", a, pred_a);
    x = a + 1;
    if (v) begin
      if (p1_live && ((u1 && rs1 == p1_rd) || (u2 && rs2 == p1_rd)) && p1_x + 3 > x)
        x = p1_x + 3;
      if (p2_live && ((u1 && rs1 == p2_rd) || (u2 && rs2 == p2_rd)) && p2_x + 3 > x)
        x = p2_x + 3;
      sbq.push_back('{pc: pc_model, rd: rd, we: we, edge_no: x + 2});
    end
    p2_x = p1_x; p2_live = p1_live; p2_rd = p1_rd;
    p1_x = x; p1_live = v && we && rd != 0; p1_rd = rd;
    pc_model++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(0, 0, 0, 0, 0, 0, 0, "R10");
  endtask

  // Monitor: compare each retirement against the scoreboard head (R10).
  always @(negedge clk) begin
    if (rst_n) begin
      if (sbq.size() > 0 && sbq[0].edge_no == edges) begin
        mon_e = sbq.pop_front();
        check(retire_valid == 1'b1, "R10", "retire_valid", int'(retire_valid), 1);
        check(int'(retire_pc) == mon_e.pc, "R10", "retire_pc", int'(retire_pc), mon_e.pc);
        check(int'(retire_rd) == mon_e.rd, "R10", "retire_rd", int'(retire_rd), mon_e.rd);
        check(retire_wen == mon_e.we, "R10", "retire_wen", int'(retire_wen), int'(mon_e.we));
      end else if (retire_valid) begin
        check(1'b0, "R10", "unexpected retire pc", int'(retire_pc), -1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(stall == 1'b0, "R1", "stall in reset", int'(stall), 0);
    check(retire_valid == 1'b0, "R1", "retire_valid in reset", int'(retire_valid), 0);
    check(fetch_pc == '0, "R1", "fetch_pc in reset", int'(fetch_pc), 0);
    rst_n = 1'b1;
    idle(2);

    // R2: consumer right behind producer, two stall cycles.
    slot(1, 1, 1, 2, 1, 3, 1, "R2");
    slot(1, 3, 1, 0, 0, 4, 1, "R2");
    idle(4);

    // R3 and R11: gap of one slot, match on the second source only.
    slot(1, 1, 1, 0, 0, 4, 1, "R3");
    slot(1, 2, 1, 0, 0, 9, 1, "R3");
    slot(1, 7, 1, 4, 1, 10, 1, "R11");
    idle(4);

    // R4: producer already in writeback.
    slot(1, 0, 0, 0, 0, 5, 1, "R4");
    slot(1, 1, 1, 0, 0, 11, 1, "R4");
    slot(1, 2, 1, 0, 0, 12, 1, "R4");
    slot(1, 5, 1, 5, 1, 13, 1, "R4");
    idle(4);

    // R5: anti and output relations only.
    slot(1, 6, 1, 1, 1, 7, 1, "R5");
    slot(1, 2, 1, 0, 0, 6, 1, "R5");
    slot(1, 2, 1, 0, 0, 6, 1, "R5");
    slot(1, 1, 1, 2, 1, 7, 1, "R5");
    idle(4);

    // R6: writer of register 0, reader of register 0.
    slot(1, 1, 1, 0, 0, 0, 1, "R6");
    slot(1, 0, 1, 0, 1, 14, 1, "R6");
    idle(4);

    // R7: matching index in an unused field.
    slot(1, 0, 0, 0, 0, 10, 1, "R7");
    slot(1, 10, 0, 10, 0, 15, 1, "R7");
    idle(4);

    // R8: non-writing and invalid slots with matching destinations.
    slot(1, 0, 0, 0, 0, 11, 0, "R8");
    slot(1, 11, 1, 0, 0, 16, 1, "R8");
    slot(0, 0, 0, 0, 0, 12, 1, "R8");
    slot(1, 0, 0, 12, 1, 17, 1, "R8");
    idle(4);

    // R2, R3, R9: dependence chain and bubble between producer and consumer.
    slot(1, 0, 0, 0, 0, 1, 1, "R9");
    slot(1, 1, 1, 0, 0, 2, 1, "R2");
    slot(1, 2, 1, 1, 1, 3, 1, "R2");
    slot(0, 0, 0, 0, 0, 0, 0, "R9");
    slot(1, 3, 1, 0, 0, 8, 1, "R3");
    slot(1, 8, 1, 3, 1, 9, 0, "R2");
    slot(1, 9, 1, 8, 1, 20, 1, "R3");
    idle(8);

    check(sbq.size() == 0, "R10", "pending retirements", sbq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule